// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block keeps the three condition flags of a small 64-bit processor core (zero, sign and signed overflow) and turns them into a single taken/not-taken decision for conditional jumps and conditional moves. In the execute step the surrounding datapath presents the result of an integer ALU operation, its two operands, the operation code and a flag-write enable. At the next rising clock edge the block captures new flags, but only when the operation is one of the four arithmetic or logic operations.

The decision side is purely combinational. The condition field of the current instruction is compared against the flags as they stand in the register, so a jump that follows a flag-setting operation sees that operation's flags one cycle later. Seven condition codes are decoded. Every other code gives not-taken.

Top module: `cc_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the flags become zf=1, sf=0, of=0 at that edge.
- R2: When `set_cc`=1 and `alu_fn` is 0 (add), 1 (sub), 2 (and) or 3 (xor), the next rising edge loads zf = (`alu_res`==0) and sf = `alu_res` bit 63.
- R3: For `alu_fn`=0 (add, `alu_res` = `op_a`+`op_b`), of is loaded as 1 exactly when `op_a` and `op_b` have equal sign bits and the sign of `alu_res` differs from them.
- R4: For `alu_fn`=1 (sub, `alu_res` = `op_a`-`op_b`), of is loaded as 1 exactly when `op_a` and `op_b` differ in sign and the sign of `alu_res` differs from that of `op_a`.
- R5: For `alu_fn`=2 or 3, of is loaded as 0.
- R6: With `set_cc`=0, all three flags keep their values across the edge, whatever the other inputs are.
- R7: With `set_cc`=1 and `alu_fn` in 4..15 (moves and other non-ALU transfers), all three flags keep their values.
- R8: `taken` follows the registered flags combinationally, with `cond_fn` decoded as 0 always, 1 le = (sf^of)|zf, 2 lt = sf^of, 3 eq = zf, 4 ne = !zf, 5 ge = !(sf^of), 6 gt = !(sf^of)&!zf.
- R9: `cond_fn` values 7..15 give `taken`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | 64 | Result of the current ALU operation |
| op_a | input | 64 | First ALU operand |
| op_b | input | 64 | Second ALU operand |
| alu_fn | input | 4 | Operation code: 0 add, 1 sub, 2 and, 3 xor, others non-ALU |
| set_cc | input | 1 | Flag-write enable for this cycle |
| cond_fn | input | 4 | Condition code of the jump or conditional move |
| zf | output | 1 | Registered zero flag |
| sf | output | 1 | Registered sign flag |
| of | output | 1 | Registered signed-overflow flag |
| taken | output | 1 | Condition holds for the current flags |

## Verification
The checker watches on every cycle that the flags hold when writes are disabled or the operation code is not an ALU operation, that the zero flag and the logic-operation overflow follow the previous cycle's inputs, that reset loads its fixed values, and that equality and out-of-range conditions decode correctly. The signed-overflow boundaries of add and subtract, the full mapping of every condition code across many flag combinations, and long mixed runs of writes, holds and transfers are only shown by the bench's directed corner cases and its seeded random sequence compared with a reference model.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned FN_W = 4;

  localparam logic [FN_W-1:0] OP_ADD = 4'd0;
  localparam logic [FN_W-1:0] OP_SUB = 4'd1;
  localparam logic [FN_W-1:0] OP_AND = 4'd2;
  localparam logic [FN_W-1:0] OP_XOR = 4'd3;

  localparam logic [FN_W-1:0] C_ALW = 4'd0;
  localparam logic [FN_W-1:0] C_LE  = 4'd1;
  localparam logic [FN_W-1:0] C_LT  = 4'd2;
  localparam logic [FN_W-1:0] C_EQ  = 4'd3;
  localparam logic [FN_W-1:0] C_NE  = 4'd4;
  localparam logic [FN_W-1:0] C_GE  = 4'd5;
  localparam logic [FN_W-1:0] C_GT  = 4'd6;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/cc_flag_calc.sv
module cc_flag_calc
  import cc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]    res,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FN_W-1:0] fn,
  output flags_t          nxt,
  output logic            fn_ok
);
  localparam int unsigned MSB = W - 1;

  logic sa, sb, sr;

  always_comb begin
    sa = a[MSB];
    sb = b[MSB];
    sr = res[MSB];
    fn_ok  = 1'b0;
    nxt.zf = (res == '0);
    nxt.sf = sr;
    nxt.of = 1'b0;
    case (fn)
      OP_ADD: begin
        fn_ok  = 1'b1;
        nxt.of = (sa == sb) && (sr != sa);
      end
      OP_SUB: begin
        fn_ok  = 1'b1;
        nxt.of = (sa != sb) && (sr != sa);
      end
      OP_AND, OP_XOR: begin
        fn_ok  = 1'b1;
        nxt.of = 1'b0;
      end
      default: fn_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= FLAGS_RST;
    else if (load)
      q <= d;
  end
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  flags_t          fl,
  input  logic [FN_W-1:0] cond,
  output logic            taken
);
  logic lt;

  always_comb begin
    lt = fl.sf ^ fl.of;
    case (cond)
      C_ALW:   taken = 1'b1;
      C_LE:    taken = lt | fl.zf;
      C_LT:    taken = lt;
      C_EQ:    taken = fl.zf;
      C_NE:    taken = ~fl.zf;
      C_GE:    taken = ~lt;
      C_GT:    taken = ~lt & ~fl.zf;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    alu_res,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [FN_W-1:0] alu_fn,
  input  logic            set_cc,
  input  logic [FN_W-1:0] cond_fn,
  output logic            zf,
  output logic            sf,
  output logic            of,
  output logic            taken
);
  flags_t nxt_fl;
  flags_t cur_fl;
  logic   fn_ok;
  logic   do_load;

  cc_flag_calc #(.W(W)) calc_i (
    .res  (alu_res),
    .a    (op_a),
    .b    (op_b),
    .fn   (alu_fn),
    .nxt  (nxt_fl),
    .fn_ok(fn_ok)
  );

  assign do_load = set_cc & fn_ok;

  cc_flag_reg reg_i (
    .clk (clk),
    .rst (rst),
    .load(do_load),
    .d   (nxt_fl),
    .q   (cur_fl)
  );

  cc_cond_eval eval_i (
    .fl   (cur_fl),
    .cond (cond_fn),
    .taken(taken)
  );

  assign zf = cur_fl.zf;
  assign sf = cur_fl.sf;
  assign of = cur_fl.of;
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] alu_res,
  input logic [3:0]   alu_fn,
  input logic         set_cc,
  input logic [3:0]   cond_fn,
  input logic         zf,
  input logic         sf,
  input logic         of,
  input logic         taken
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  a_r1_reset_flags: assert property (@(posedge clk)
    rst_seen |-> (zf && !sf && !of));

  // R6
  a_r6_hold_no_write: assert property (@(posedge clk) disable iff (rst)
    !set_cc |=> ($stable(zf) && $stable(sf) && $stable(of)));

  // R7
  a_r7_non_alu_hold: assert property (@(posedge clk) disable iff (rst)
    (set_cc && alu_fn > 4'd3) |=> ($stable(zf) && $stable(sf) && $stable(of)));

  // R2
  a_r2_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (set_cc && alu_fn <= 4'd3) |=> (zf == ($past(alu_res) == '0)));

  // R5
  a_r5_logic_clears_of: assert property (@(posedge clk) disable iff (rst)
    (set_cc && (alu_fn == 4'd2 || alu_fn == 4'd3)) |=> !of);

  // R8
  a_r8_equal_cond: assert property (@(posedge clk) disable iff (rst)
    (cond_fn == 4'd3) |-> (taken == zf));

  // R9
  a_r9_bad_cond: assert property (@(posedge clk) disable iff (rst)
    (cond_fn > 4'd6) |-> !taken);
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .alu_res(alu_res),
  .alu_fn (alu_fn),
  .set_cc (set_cc),
  .cond_fn(cond_fn),
  .zf     (zf),
  .sf     (sf),
  .of     (of),
  .taken  (taken)
);

// File: tb/cc_branch_unit_tb_top.sv
module cc_branch_unit_tb_top;
  localparam int W = 64;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 3000;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] alu_res, op_a, op_b;
  logic [3:0]   alu_fn, cond_fn;
  logic         set_cc;
  logic         zf, sf, of, taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_zf, m_sf, m_of;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_branch_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .alu_res(alu_res), .op_a(op_a), .op_b(op_b),
    .alu_fn(alu_fn), .set_cc(set_cc), .cond_fn(cond_fn),
    .zf(zf), .sf(sf), .of(of), .taken(taken)
  );

  function automatic logic [W-1:0] ref_res(logic [3:0] f, logic [W-1:0] a, logic [W-1:0] b);
    case (f)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a ^ b;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  function automatic bit ref_taken(logic [3:0] c, bit z, bit s, bit o);
    case (c)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_update(logic s, logic [3:0] f, logic [W-1:0] r, logic [W-1:0] a, logic [W-1:0] b);
    if (s && f <= 4'd3) begin
      m_zf = (r == '0);
      m_sf = r[W-1];
      case (f)
        4'd0: m_of = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
        4'd1: m_of = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        default: m_of = 1'b0;
      endcase
    end
  endtask

  function automatic string req_of(logic s, logic [3:0] f);
    if (!s) return "R6";
    if (f > 4'd3) return "R7";
    if (f == 4'd0) return "R3";
    if (f == 4'd1) return "R4";
    return "R5";
  endfunction

  // One operation: drive at negedge, check taken, clock, check flags.
  task automatic step(logic s, logic [3:0] f, logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
    logic [W-1:0] r;
    string rq;
    r = ref_res(f, a, b);
    op_a = a; op_b = b; alu_fn = f; alu_res = r; set_cc = s; cond_fn = c;
    #1;
    chk((c > 4'd6) ? "R9" : "R8", {31'd0, taken}, {31'd0, ref_taken(c, m_zf, m_sf, m_of)});
    @(posedge clk);
    model_update(s, f, r, a, b);
    @(negedge clk);
    chk("R2", {30'd0, zf, sf}, {30'd0, m_zf, m_sf});
    rq = req_of(s, f);
    chk(rq, {31'd0, of}, {31'd0, m_of});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; set_cc = 1'b1; alu_fn = 4'd0; cond_fn = 4'd0;
    op_a = '1; op_b = '1; alu_res = 64'h8000_0000_0000_0001;
    @(negedge clk); @(negedge clk);
    // R1: reset wins over a pending write
    chk("R1", {29'd0, zf, sf, of}, {29'd0, 3'b100});
    m_zf = 1; m_sf = 0; m_of = 0;
    rst = 1'b0;

    // R3: positive overflow on add
    step(1, 4'd0, 64'h7fff_ffff_ffff_ffff, 64'd1, 4'd0);
    chk("R3", {31'd0, of}, 32'd1);
    // R8 lt with sf=1, of=1 -> not taken
    step(0, 4'd0, 0, 0, 4'd2);
    // R3: negative+negative wrapping to zero
    step(1, 4'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 4'd3);
    chk("R3", {29'd0, zf, sf, of}, {29'd0, 3'b101});
    // R4: min - 1 overflows
    step(1, 4'd1, 64'h8000_0000_0000_0000, 64'd1, 4'd1);
    chk("R4", {29'd0, zf, sf, of}, {29'd0, 3'b001});
    // R4: equal operands give zero, no overflow
    step(1, 4'd1, 64'd5, 64'd5, 4'd6);
    chk("R4", {29'd0, zf, sf, of}, {29'd0, 3'b100});
    // R5: xor negative clears of
    step(1, 4'd1, 64'h8000_0000_0000_0000, 64'd1, 4'd5);
    step(1, 4'd3, 64'hffff_0000_0000_0000, 64'd0, 4'd4);
    chk("R5", {29'd0, zf, sf, of}, {29'd0, 3'b010});
    // R7: non-ALU code with write enable keeps flags
    step(1, 4'd9, 64'd0, 64'd0, 4'd7);
    chk("R7", {29'd0, zf, sf, of}, {29'd0, 3'b010});
    // R6: write disabled keeps flags
    step(0, 4'd2, 64'd0, 64'd0, 4'd15);
    chk("R6", {29'd0, zf, sf, of}, {29'd0, 3'b010});
    // R8/R9: every condition against the current flags
    for (int c = 0; c < 16; c++) step(0, 4'd0, 0, 0, c[3:0]);

    for (int i = 0; i < N_RAND; i++) begin
      logic [W-1:0] a, b;
      logic [3:0] f;
      logic s;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: a = b;
        1: b = a;
        2: a[W-1:W-2] = 2'b01;
        default: ;
      endcase
      f = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
      s = ($urandom_range(0, 4) != 0);
      step(s, f, a, b, 4'($urandom_range(0, 15)));
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule